// File: doc/BRIEF.md
# YUYV Raster to 4:2:2 MCU Block Reorderer

This block sits in front of a block-transform stage. It takes packed 4:2:2 video in raster order on an AXI4-Stream slave. Each 16-bit word is one pixel: the luma sits in the low byte, and the high byte alternates between the blue-difference and red-difference chroma from one pixel to the next. The block writes incoming scanlines into one simple dual-port RAM. That RAM is split into two banks of eight lines each.

Once a bank holds a complete band of eight lines, a read sequencer replays it as 8x8 sample blocks in minimum-coded-unit order. Each MCU covers 16x8 pixels and produces two luma blocks, then one Cb block, then one Cr block. The output is a valid/ready byte stream. Each sample carries a 2-bit block tag and a flag on the last sample of its block.

While one bank is being drained, the other bank fills. Input backpressure appears only when both banks hold undrained bands. Frame width and height are compile-time parameters. The width must be a multiple of 16 and the height a multiple of 8.

Top module: `yuyv_mcu_reorder`

## Requirements
- R1: In a word at an even column, bits [15:8] are Cb and bits [7:0] are Y. In a word at an odd column, bits [15:8] are Cr and bits [7:0] are Y. Luma blocks carry only low bytes. Cb blocks carry only high bytes of even columns, and Cr blocks only high bytes of odd columns.
- R2: Bands of eight lines are emitted top to bottom, and the MCUs of a band left to right. Each MCU emits four blocks tagged on m_type_o: 0 = luma columns 0-7 of the MCU, 1 = luma columns 8-15, 2 = Cb, 3 = Cr.
- R3: Every block is 64 samples in row-major order (column index fastest). m_last_o is high on the 64th sample and low on the other 63.
- R4: Chroma sample k (0..7) of a block row in MCU m comes from pixel column 16m+2k for Cb and from column 16m+2k+1 for Cr. Luma sample k of block tag t comes from column 16m+8t+k.
- R5: No sample of a band is presented until all eight of its lines have been accepted.
- R6: After reset s_tready_o is high. It goes low only while both banks hold complete bands that have not been fully read.
- R7: While m_valid_o is high and m_ready_i is low, m_valid_o, m_sample_o, m_type_o and m_last_o hold their values.
- R8: A word accepted with s_tuser_i high is stored as column 0 of line 0 of a band. Any partial band before it is discarded and never emitted.
- R9: A 16-pixel-wide frame (one MCU per band) is reordered correctly, including the wrap of the MCU column counter.
- R10: Idle cycles on s_tvalid_i or m_ready_i change neither the content nor the order of the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | 16 | Pixel word {chroma, luma} |
| s_tvalid_i | input | 1 | Input word valid |
| s_tready_o | output | 1 | Input word accepted when high with valid |
| s_tlast_i | input | 1 | Last pixel of a scanline |
| s_tuser_i | input | 1 | First pixel of a frame |
| m_valid_o | output | 1 | Output sample valid |
| m_ready_i | input | 1 | Downstream accepts sample |
| m_sample_o | output | 8 | Sample byte |
| m_type_o | output | 2 | Block tag (0/1 luma, 2 Cb, 3 Cr) |
| m_last_o | output | 1 | Last sample of the current block |

## Verification
The assertions rely on s_tlast_i arriving exactly on column IMG_W-1 of every line. They also rely on s_tuser_i appearing only on a word meant to start a frame. The stimulus builds every line from its column index, so tlast is raised only on the final column. The single deliberately truncated frame leaves its last line unfinished without raising tlast, and the next word carries tuser. Gaps on the input and a randomly toggled ready on the output keep the handshake rules intact, because the bench only changes inputs between clock edges.

// File: rtl/yuyv_mcu_pkg.sv
package yuyv_mcu_pkg;
  typedef enum logic [1:0] {
    BLK_Y0 = 2'd0,
    BLK_Y1 = 2'd1,
    BLK_CB = 2'd2,
    BLK_CR = 2'd3
  } blk_e;

  localparam int BAND_LINES = 8;
  localparam int MCU_W      = 16;
endpackage

// File: rtl/sdp_ram.sv
module sdp_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read data holds while re_i is low; the reader relies on this
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/yuyv_line_writer.sv
module yuyv_line_writer
  import yuyv_mcu_pkg::*;
#(
  parameter int IMG_W  = 64,
  localparam int CW    = $clog2(IMG_W),
  localparam int BANKW = BAND_LINES * IMG_W,
  localparam int AW    = $clog2(2 * BANKW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   tdata_i,
  input  logic          tvalid_i,
  output logic          tready_o,
  input  logic          tlast_i,
  input  logic          tuser_i,
  input  logic [1:0]    rel_i,
  output logic [1:0]    full_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [15:0]   wdata_o
);
  logic [CW-1:0] col_q, col_eff;
  logic [2:0]    line_q, line_eff;
  logic          wb_q;
  logic [1:0]    full_q, set_full;
  logic          accept, end_line, band_done;

  assign tready_o  = !full_q[wb_q];
  assign accept    = tvalid_i && tready_o;
  // tuser forces the current word to the band origin
  assign col_eff   = tuser_i ? '0 : col_q;
  assign line_eff  = tuser_i ? '0 : line_q;
  assign end_line  = (int'(col_eff) == IMG_W - 1);
  assign band_done = end_line && (line_eff == 3'd7);

  assign we_o    = accept;
  assign wdata_o = tdata_i;
  assign waddr_o = AW'(int'(wb_q) * BANKW + int'(line_eff) * IMG_W + int'(col_eff));

  always_comb begin
    set_full = '0;
    if (accept && band_done) set_full[wb_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      line_q <= '0;
      wb_q   <= 1'b0;
      full_q <= '0;
    end else begin
      full_q <= (full_q & ~rel_i) | set_full;
      if (accept) begin
        col_q <= end_line ? '0 : col_eff + 1'b1;
        if (end_line) line_q <= line_eff + 3'd1;
        else          line_q <= line_eff;
        if (band_done) wb_q <= !wb_q;
      end
    end
  end

  assign full_o = full_q;

  AST_TLAST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (tlast_i == end_line)); // R8

  for (genvar b = 0; b < 2; b++) begin : g_bank_chk
    AST_BANK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_q[b] && !rel_i[b] |=> full_q[b]); // R6
    AST_REL_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_i[b] |-> full_q[b]); // R6
  end
endmodule

// File: rtl/mcu_block_reader.sv
module mcu_block_reader
  import yuyv_mcu_pkg::*;
#(
  parameter int IMG_W  = 64,
  localparam int MCUS  = IMG_W / MCU_W,
  localparam int MW    = $clog2(MCUS > 1 ? MCUS : 2),
  localparam int BANKW = BAND_LINES * IMG_W,
  localparam int AW    = $clog2(2 * BANKW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    full_i,
  output logic [1:0]    rel_o,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  input  logic [15:0]   rdata_i,
  input  logic          m_ready_i,
  output logic          m_valid_o,
  output logic [7:0]    m_sample_o,
  output logic [1:0]    m_type_o,
  output logic          m_last_o
);
  logic          rb_q;
  logic [MW-1:0] mcu_q;
  blk_e          blk_q;
  logic [2:0]    row_q, k_q;
  logic          have, out_take, issue_ok, issue;
  logic          blk_end, band_end;
  int            col;

  // stage 1: read issued, data sits in RAM output register
  logic          s1_v_q, s1_hi_q, s1_last_q;
  blk_e          s1_type_q;
  // stage 2: output register
  logic          out_v_q, out_last_q;
  logic [7:0]    out_smp_q;
  blk_e          out_type_q;

  assign have     = full_i[rb_q];
  assign out_take = !out_v_q || m_ready_i;
  assign issue_ok = !s1_v_q || out_take;
  assign issue    = have && issue_ok;
  assign blk_end  = (k_q == 3'd7) && (row_q == 3'd7);
  assign band_end = blk_end && (blk_q == BLK_CR) && (int'(mcu_q) == MCUS - 1);

  always_comb begin
    if (blk_q == BLK_Y0 || blk_q == BLK_Y1)
      col = int'(mcu_q) * MCU_W + (blk_q == BLK_Y1 ? 8 : 0) + int'(k_q);
    else
      col = int'(mcu_q) * MCU_W + 2 * int'(k_q) + (blk_q == BLK_CR ? 1 : 0);
  end

  assign re_o    = issue;
  assign raddr_o = AW'(int'(rb_q) * BANKW + int'(row_q) * IMG_W + col);

  always_comb begin
    rel_o = '0;
    if (issue && band_end) rel_o[rb_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q  <= 1'b0;
      mcu_q <= '0;
      blk_q <= BLK_Y0;
      row_q <= '0;
      k_q   <= '0;
    end else if (issue) begin
      k_q <= k_q + 3'd1;
      if (k_q == 3'd7) row_q <= row_q + 3'd1;
      if (blk_end) begin
        blk_q <= blk_e'(2'(blk_q) + 2'd1);
        if (blk_q == BLK_CR) begin
          if (int'(mcu_q) == MCUS - 1) begin
            mcu_q <= '0;
            rb_q  <= !rb_q;
          end else begin
            mcu_q <= mcu_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q    <= 1'b0;
      s1_hi_q   <= 1'b0;
      s1_last_q <= 1'b0;
      s1_type_q <= BLK_Y0;
    end else if (issue_ok) begin
      s1_v_q    <= issue;
      s1_hi_q   <= (blk_q == BLK_CB) || (blk_q == BLK_CR);
      s1_last_q <= blk_end;
      s1_type_q <= blk_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q    <= 1'b0;
      out_smp_q  <= '0;
      out_last_q <= 1'b0;
      out_type_q <= BLK_Y0;
    end else if (out_take) begin
      out_v_q    <= s1_v_q;
      out_smp_q  <= s1_hi_q ? rdata_i[15:8] : rdata_i[7:0];
      out_last_q <= s1_last_q;
      out_type_q <= s1_type_q;
    end
  end

  assign m_valid_o  = out_v_q;
  assign m_sample_o = out_smp_q;
  assign m_type_o   = out_type_q;
  assign m_last_o   = out_last_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_sample_o)
      && $stable(m_type_o) && $stable(m_last_o)); // R7
  AST_REL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rel_o)); // R6
  AST_READ_FROM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |-> full_i[rb_q]); // R5
endmodule

// File: rtl/yuyv_mcu_reorder.sv
module yuyv_mcu_reorder
  import yuyv_mcu_pkg::*;
#(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 32,
  localparam int DEPTH = 2 * BAND_LINES * IMG_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] s_tdata_i,
  input  logic        s_tvalid_i,
  output logic        s_tready_o,
  input  logic        s_tlast_i,
  input  logic        s_tuser_i,
  output logic        m_valid_o,
  input  logic        m_ready_i,
  output logic [7:0]  m_sample_o,
  output logic [1:0]  m_type_o,
  output logic        m_last_o
);
  logic [1:0]    full, rel;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [15:0]   wdata, rdata;

  initial begin
    AST_GEOMETRY: assert (IMG_W % MCU_W == 0 && IMG_W >= MCU_W
      && IMG_H % BAND_LINES == 0 && IMG_H >= BAND_LINES); // R9
  end

  yuyv_line_writer #(.IMG_W(IMG_W)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tdata_i  (s_tdata_i),
    .tvalid_i (s_tvalid_i),
    .tready_o (s_tready_o),
    .tlast_i  (s_tlast_i),
    .tuser_i  (s_tuser_i),
    .rel_i    (rel),
    .full_o   (full),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata)
  );

  sdp_ram #(.DW(16), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  mcu_block_reader #(.IMG_W(IMG_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .full_i     (full),
    .rel_o      (rel),
    .re_o       (re),
    .raddr_o    (raddr),
    .rdata_i    (rdata),
    .m_ready_i  (m_ready_i),
    .m_valid_o  (m_valid_o),
    .m_sample_o (m_sample_o),
    .m_type_o   (m_type_o),
    .m_last_o   (m_last_o)
  );

  // output-side block framing monitor
  logic [5:0] hs_cnt_q;
  blk_e       exp_blk_q;
  logic       hs;
  assign hs = m_valid_o && m_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_cnt_q  <= '0;
      exp_blk_q <= BLK_Y0;
    end else if (hs) begin
      hs_cnt_q <= hs_cnt_q + 6'd1;
      if (m_last_o) exp_blk_q <= blk_e'(2'(exp_blk_q) + 2'd1);
    end
  end

  AST_LAST_AT_64: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |-> (m_last_o == (hs_cnt_q == 6'd63))); // R3
  AST_BLK_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |-> (m_type_o == 2'(exp_blk_q))); // R2
  AST_NO_WRITE_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_tready_o |-> (full == 2'b11)); // R6
endmodule

// File: tb/tb_yuyv_mcu_reorder.sv
`timescale 1ns/1ps
module tb_yuyv_mcu_reorder;
  localparam int WA = 32, HA = 16;
  localparam int WB = 16, HB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0, s_user = 1'b0, use_min = 1'b0;
  logic rdy_a, rdy_b, s_rdy;
  logic m_rdy = 1'b0;
  int   rdy_mode = 0;

  logic       va, vb, la, lb;
  logic [7:0] sa, sb;
  logic [1:0] ta, tb;

  int n_chk = 0, n_bad = 0;
  int idx_a = 0, fr_a = 0, tot_a = 0;
  int idx_b = 0, fr_b = 0, tot_b = 0;
  int cyc = 0;

  yuyv_mcu_reorder #(.IMG_W(WA), .IMG_H(HA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .s_tdata_i(s_data),
    .s_tvalid_i(s_valid && !use_min), .s_tready_o(rdy_a),
    .s_tlast_i(s_last), .s_tuser_i(s_user),
    .m_valid_o(va), .m_ready_i(m_rdy), .m_sample_o(sa),
    .m_type_o(ta), .m_last_o(la));

  yuyv_mcu_reorder #(.IMG_W(WB), .IMG_H(HB)) dut_min (
    .clk_i(clk), .rst_ni(rst_n), .s_tdata_i(s_data),
    .s_tvalid_i(s_valid && use_min), .s_tready_o(rdy_b),
    .s_tlast_i(s_last), .s_tuser_i(s_user),
    .m_valid_o(vb), .m_ready_i(m_rdy), .m_sample_o(sb),
    .m_type_o(tb), .m_last_o(lb));

  assign s_rdy = use_min ? rdy_b : rdy_a;

  always @(posedge clk) begin
    if (rdy_mode == 0)      m_rdy <= 1'b1;
    else if (rdy_mode == 1) m_rdy <= ($urandom_range(0, 3) != 0);
    else                    m_rdy <= 1'b0;
  end

  function automatic int luma(int x, int y, int f);
    return (x * 7 + y * 13 + f * 29) & 255;
  endfunction
  function automatic int chroma(int x, int y, int f);
    return (x * 3 + y * 5 + f * 11 + ((x & 1) != 0 ? 128 : 0)) & 255;
  endfunction

  // {last, type, sample} expected for sample idx of frame f
  function automatic logic [10:0] expect_of(int w, int f, int idx);
    int band, r, m, q, blk, s, row, k, y, x, v;
    band = idx / (w * 16);
    r    = idx % (w * 16);
    m    = r / 256;
    q    = r % 256;
    blk  = q / 64;
    s    = q % 64;
    row  = s / 8;
    k    = s % 8;
    y    = band * 8 + row;
    if (blk < 2) begin
      x = m * 16 + blk * 8 + k;
      v = luma(x, y, f);
    end else begin
      x = m * 16 + 2 * k + (blk == 3 ? 1 : 0);
      v = chroma(x, y, f);
    end
    return {(s == 63), 2'(blk), 8'(v)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && va && m_rdy) begin
      logic [10:0] e;
      e = expect_of(WA, fr_a, idx_a);
      chk({la, ta, sa} == e, "R1/R2/R3/R4/R10 main stream", int'({la, ta, sa}), int'(e));
      idx_a++; tot_a++;
      if (idx_a == WA * HA * 2) begin idx_a = 0; fr_a++; end
    end
    if (rst_n && vb && m_rdy) begin
      logic [10:0] e;
      e = expect_of(WB, fr_b, idx_b);
      chk({lb, tb, sb} == e, "R9 single-MCU stream", int'({lb, tb, sb}), int'(e));
      idx_b++; tot_b++;
      if (idx_b == WB * HB * 2) begin idx_b = 0; fr_b++; end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  task automatic send_word(logic [15:0] d, bit last, bit user, bit gaps);
    s_data = d; s_last = last; s_user = user; s_valid = 1'b1;
    while (!s_rdy) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; s_user = 1'b0;
    if (gaps) repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  task automatic send_line(int w, int y, int f, bit sof, bit gaps, int ncols);
    for (int x = 0; x < ncols; x++)
      send_word({8'(chroma(x, y, f)), 8'(luma(x, y, f))},
                x == w - 1, sof && x == 0 && y == 0, gaps);
  endtask

  task automatic send_frame(int w, int h, int f, bit gaps);
    for (int y = 0; y < h; y++) send_line(w, y, f, 1'b1, gaps, w);
  endtask

  task automatic wait_tot(int want_a, int want_b);
    while (tot_a < want_a || tot_b < want_b) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_a == 1'b1 && rdy_b == 1'b1, "R6 reset tready", int'(rdy_a), 1);
    chk(va == 1'b0 && vb == 1'b0, "R5 reset valid", int'(va), 0);

    // frame 0: check nothing appears before the 8th line
    rdy_mode = 0;
    for (int y = 0; y < 7; y++) send_line(WA, y, 0, 1'b1, 1'b0, WA);
    repeat (20) @(negedge clk);
    chk(va == 1'b0 && tot_a == 0, "R5 no output after 7 lines", tot_a, 0);
    for (int y = 7; y < HA; y++) send_line(WA, y, 0, 1'b1, 1'b0, WA);
    wait_tot(2048 / 2, 0);

    // frame 1: input gaps and random ready
    rdy_mode = 1;
    send_frame(WA, HA, 1, 1'b1);
    wait_tot(2048, 0);

    // frame 2: ready held low so both banks fill
    rdy_mode = 2;
    repeat (3) @(negedge clk);
    for (int y = 0; y < 8; y++) send_line(WA, y, 2, 1'b1, 1'b0, WA);
    repeat (10) @(negedge clk);
    chk(rdy_a == 1'b1, "R6 tready high with one bank full", int'(rdy_a), 1);
    for (int y = 8; y < HA; y++) send_line(WA, y, 2, 1'b1, 1'b0, WA);
    repeat (10) @(negedge clk);
    chk(rdy_a == 1'b0, "R6 tready low with both banks full", int'(rdy_a), 0);
    chk(va == 1'b1, "R5 band ready to emit", int'(va), 1);
    begin
      logic [10:0] held;
      held = {la, ta, sa};
      repeat (6) @(negedge clk);
      chk({la, ta, sa} == held && va, "R7 outputs held under stall", int'({la, ta, sa}), int'(held));
    end
    rdy_mode = 1;
    wait_tot(3072, 0);

    // truncated frame, then resync on tuser with frame 3
    for (int y = 0; y < 2; y++) send_line(WA, y, 99, 1'b1, 1'b0, WA);
    send_line(WA, 2, 99, 1'b1, 1'b0, 5);
    repeat (15) @(negedge clk);
    chk(va == 1'b0 && tot_a == 3072, "R8 partial band not emitted", tot_a, 3072);
    send_frame(WA, HA, 3, 1'b1);
    wait_tot(4096, 0);
    chk(tot_a == 4096 && fr_a == 4, "R8 resync frame count", fr_a, 4);

    // single-MCU-wide configuration
    use_min = 1'b1;
    send_frame(WB, HB, 0, 1'b1);
    send_frame(WB, HB, 1, 1'b0);
    wait_tot(4096, 512);
    repeat (20) @(negedge clk);
    chk(tot_b == 512 && fr_b == 2, "R9 single-MCU sample total", tot_b, 512);
    chk(tot_a == 4096, "R2 no extra samples", tot_a, 4096);
    chk(va == 1'b0 && vb == 1'b0, "R10 idle after drain", int'(va | vb), 0);
    summary();
  end
endmodule